// File: doc/BRIEF.md
# Sub-scan Laplacian Sharpening Filter

This block sharpens a raster image across scan lines. Each cycle it may take three vertically stacked pixels at the same horizontal position: the pixel of the line now arriving, the same column one line earlier, and the same column two lines earlier. In a system these come from the raw pixel stream and from the two taps of a cascaded line-delay memory. The middle pixel is the one being corrected. Its two vertical neighbours give a second-difference (Laplacian) term. That term is scaled by a coefficient and added back to the middle pixel, so edges that run along the main scan direction are emphasised.

The datapath is a three-stage pipeline with full throughput. It accepts one pixel triplet per clock, and each accepted triplet produces exactly one corrected pixel three clocks later. The coefficient is an unsigned fixed-point input. It travels down the pipeline with its pixel, so it may change from one pixel to the next. The line memory and any handling of image borders are outside this block.

Top module: `subscan_sharpen`

## Requirements
- R1: For an accepted triplet with next-line pixel `pix_next`, centre pixel `pix_mid` and previous-line pixel `pix_prev`, the output is clamp(`pix_mid` + S), where S is the rounded value of K·(2·`pix_mid` − `pix_prev` − `pix_next`) computed without overflow.
- R2: `coef_k` is unsigned fixed point. Bits 7:4 hold the integer part and bits 3:0 hold the fraction, so K = `coef_k`/16.
- R3: S = floor((`coef_k`·L + 8) / 16) with L = 2·`pix_mid` − `pix_prev` − `pix_next`. This rounds to nearest, and exact halves go toward +infinity.
- R4: Results below 0 give 0 and results above 255 give 255.
- R5: `out_valid` is high exactly three clock edges after `in_valid` was sampled high, and low otherwise. Back-to-back triplets are accepted on every cycle.
- R6: The coefficient applied to a pixel is the value of `coef_k` sampled in the same cycle as that pixel. Later changes to `coef_k` do not alter it.
- R7: When `coef_k` is zero, the output equals `pix_mid` exactly.
- R8: When all three input pixels are equal, the output equals `pix_mid` for any coefficient.
- R9: While `out_valid` is low, `out_pix` holds the last valid result. Input values presented with `in_valid` low have no effect.
- R10: After reset, `out_valid` is 0 and `out_pix` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Triplet and coefficient are valid this cycle |
| pix_next | input | 8 | Undelayed pixel (line n+1) |
| pix_mid | input | 8 | One-line-delayed pixel (line n, corrected) |
| pix_prev | input | 8 | Two-line-delayed pixel (line n−1) |
| coef_k | input | 8 | Sharpening coefficient, unsigned 4.4 |
| out_valid | output | 1 | Corrected pixel valid |
| out_pix | output | 8 | Corrected pixel |

## Verification
Several properties are checked on every cycle by the assertions:
- the valid strobe advances one stage per clock;
- a zero coefficient, or three equal pixels, returns the centre pixel three cycles later;
- a saturating triplet produces full scale;
- the output register stays still while no result arrives.

Other behaviours depend on exact numbers and can only be shown by the bench's scenarios:
- the rounding of exact halves in both signs;
- the weight of the integer and fraction bits of the coefficient;
- the coefficient staying bound to its own pixel when it changes every cycle;
- clamping at both ends under random data.

// File: rtl/subscan_pkg.sv
package subscan_pkg;
   // number of register stages from input to output
   localparam int PIPE_STAGES = 3;

   // selects how the scaled Laplacian drops its fraction bits
   typedef enum logic {
      RND_NEAREST = 1'b0,
      RND_TRUNC   = 1'b1
   } rnd_mode_e;
endpackage

// File: rtl/ssf_gather.sv
// Stage 1: neighbour sum and doubled centre.
module ssf_gather #(
   parameter int PIX_W = 8,
   parameter int K_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             v_i,
   input  logic [PIX_W-1:0] a_i,
   input  logic [PIX_W-1:0] n_i,
   input  logic [PIX_W-1:0] b_i,
   input  logic [K_W-1:0]   k_i,
   output logic             v_o,
   output logic [PIX_W:0]   sum_o,
   output logic [PIX_W:0]   dbl_o,
   output logic [PIX_W-1:0] n_o,
   output logic [K_W-1:0]   k_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_o   <= 1'b0;
         sum_o <= '0;
         dbl_o <= '0;
         n_o   <= '0;
         k_o   <= '0;
      end else begin
         v_o <= v_i;
         if (v_i) begin
            sum_o <= {1'b0, a_i} + {1'b0, b_i};
            dbl_o <= {n_i, 1'b0};
            n_o   <= n_i;
            k_o   <= k_i;
         end
      end
   end

   // R5: valid advances one stage per clock
   p_valid_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      v_i |=> v_o);
   p_valid_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !v_i |=> !v_o);
endmodule

// File: rtl/ssf_scale.sv
// Stage 2: Laplacian, coefficient product and fraction removal.
module ssf_scale
   import subscan_pkg::*;
#(
   parameter int        PIX_W  = 8,
   parameter int        K_INT  = 4,
   parameter int        K_FRAC = 4,
   parameter rnd_mode_e RND    = RND_NEAREST,
   localparam int       K_W    = K_INT + K_FRAC,
   localparam int       LAP_W  = PIX_W + 2,
   localparam int       PROD_W = LAP_W + K_W + 1,
   localparam int       SC_W   = PROD_W - K_FRAC
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   v_i,
   input  logic [PIX_W:0]         sum_i,
   input  logic [PIX_W:0]         dbl_i,
   input  logic [PIX_W-1:0]       n_i,
   input  logic [K_W-1:0]         k_i,
   output logic                   v_o,
   output logic signed [SC_W-1:0] sc_o,
   output logic [PIX_W-1:0]       n_o
);
   logic signed [LAP_W-1:0]  lap;
   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] prod_adj;

   always_comb begin
      lap  = $signed({1'b0, dbl_i}) - $signed({1'b0, sum_i});
      prod = lap * $signed({1'b0, k_i});
   end

   generate
      if (RND == RND_NEAREST && K_FRAC > 0) begin : g_round
         localparam logic [PROD_W-1:0] HALF = PROD_W'(1) << (K_FRAC - 1);
         always_comb prod_adj = prod + $signed(HALF);
      end else begin : g_trunc
         always_comb prod_adj = prod;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_o  <= 1'b0;
         sc_o <= '0;
         n_o  <= '0;
      end else begin
         v_o <= v_i;
         if (v_i) begin
            sc_o <= prod_adj[PROD_W-1:K_FRAC];
            n_o  <= n_i;
         end
      end
   end

   // R7: a zero coefficient yields no correction
   p_zero_coef_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i && k_i == '0) |=> sc_o == '0);
   // R8: equal neighbours and centre give no correction
   p_flat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i && sum_i == dbl_i) |=> sc_o == '0);
   p_valid_step2_r5: assert property (@(posedge clk) disable iff (!rst_n)
      v_i |=> v_o);
endmodule

// File: rtl/ssf_merge.sv
// Stage 3: add correction to centre and saturate.
module ssf_merge #(
   parameter int  PIX_W = 8,
   parameter int  SC_W  = 15,
   localparam int M_W   = SC_W + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   v_i,
   input  logic signed [SC_W-1:0] sc_i,
   input  logic [PIX_W-1:0]       n_i,
   output logic                   v_o,
   output logic [PIX_W-1:0]       pix_o
);
   localparam logic [M_W-1:0] PMAX = M_W'((1 << PIX_W) - 1);

   logic signed [M_W-1:0] acc;
   logic [PIX_W-1:0]      sat;

   always_comb begin
      acc = $signed({{(M_W - PIX_W){1'b0}}, n_i}) + $signed({sc_i[SC_W-1], sc_i});
      if (acc[M_W-1])
         sat = '0;
      else if (acc > $signed(PMAX))
         sat = '1;
      else
         sat = acc[PIX_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_o   <= 1'b0;
         pix_o <= '0;
      end else begin
         v_o <= v_i;
         if (v_i) pix_o <= sat;
      end
   end

   // R9: output register holds while nothing arrives
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !v_i |=> $stable(pix_o));
   // R4: a non-negative correction never lowers the centre pixel
   p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i && !sc_i[SC_W-1]) |=> pix_o >= $past(n_i));
   p_valid_step3_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !v_i |=> !v_o);
endmodule

// File: rtl/subscan_sharpen.sv
module subscan_sharpen
   import subscan_pkg::*;
#(
   parameter int        PIX_W  = 8,
   parameter int        K_INT  = 4,
   parameter int        K_FRAC = 4,
   parameter rnd_mode_e RND    = RND_NEAREST,
   localparam int       K_W    = K_INT + K_FRAC,
   localparam int       SC_W   = PIX_W + 2 + K_W + 1 - K_FRAC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [PIX_W-1:0] pix_next,
   input  logic [PIX_W-1:0] pix_mid,
   input  logic [PIX_W-1:0] pix_prev,
   input  logic [K_W-1:0]   coef_k,
   output logic             out_valid,
   output logic [PIX_W-1:0] out_pix
);
   initial begin
      assert (PIX_W >= 2) else $error("PIX_W must be at least 2");
      assert (K_INT >= 1) else $error("K_INT must be at least 1");
      assert (K_FRAC >= 0) else $error("K_FRAC must not be negative");
      assert (PIPE_STAGES == 3) else $error("pipeline depth mismatch");
   end

   logic             v1, v2;
   logic [PIX_W:0]   sum1, dbl1;
   logic [PIX_W-1:0] n1, n2;
   logic [K_W-1:0]   k1;
   logic signed [SC_W-1:0] sc2;

   ssf_gather #(.PIX_W(PIX_W), .K_W(K_W)) u_gather (
      .clk(clk), .rst_n(rst_n), .v_i(in_valid),
      .a_i(pix_prev), .n_i(pix_mid), .b_i(pix_next), .k_i(coef_k),
      .v_o(v1), .sum_o(sum1), .dbl_o(dbl1), .n_o(n1), .k_o(k1)
   );

   ssf_scale #(.PIX_W(PIX_W), .K_INT(K_INT), .K_FRAC(K_FRAC), .RND(RND)) u_scale (
      .clk(clk), .rst_n(rst_n), .v_i(v1),
      .sum_i(sum1), .dbl_i(dbl1), .n_i(n1), .k_i(k1),
      .v_o(v2), .sc_o(sc2), .n_o(n2)
   );

   ssf_merge #(.PIX_W(PIX_W), .SC_W(SC_W)) u_merge (
      .clk(clk), .rst_n(rst_n), .v_i(v2), .sc_i(sc2), .n_i(n2),
      .v_o(out_valid), .pix_o(out_pix)
   );

   // R7: zero coefficient passes the centre pixel through
   p_k0_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(coef_k, 3) == '0) |-> out_pix == $past(pix_mid, 3));
   // R8: flat column passes the centre pixel through
   p_flat_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(pix_prev == pix_mid && pix_next == pix_mid, 3))
      |-> out_pix == $past(pix_mid, 3));
   // R4: strongest positive correction saturates high
   p_sat_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(pix_mid == '1 && pix_prev == '0 && pix_next == '0
                          && coef_k >= K_W'(1 << K_FRAC), 3))
      |-> out_pix == '1);
endmodule

// File: tb/tb_subscan_sharpen.sv
module tb_subscan_sharpen;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       in_valid;
   logic [7:0] pix_next, pix_mid, pix_prev, coef_k;
   logic       out_valid;
   logic [7:0] out_pix;

   int n_run  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 0;

   bit    hv[3];
   int    hp[3];
   string ht[3];
   int    last_good = 0;

   always #4 clk = ~clk;

   subscan_sharpen dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .pix_next(pix_next), .pix_mid(pix_mid), .pix_prev(pix_prev),
      .coef_k(coef_k), .out_valid(out_valid), .out_pix(out_pix)
   );

   function automatic int model(int a, int n, int b, int k);
      int l, s, r;
      l = 2 * n - a - b;
      s = (k * l + 8) >>> 4;
      r = n + s;
      if (r < 0) r = 0;
      if (r > 255) r = 255;
      return r;
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: %s got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_fail++;
         $display("FAIL watchdog: cycles got %0d expected below 150000", cyc);
         finish_run();
      end
   end

   // one cycle: check what arrives now, then present the next input
   task automatic step(bit v, int a, int n, int b, int k, string tag);
      @(negedge clk);
      if (hv[2]) begin
         check("R5", "out_valid", int'(out_valid), 1);
         check(ht[2], "out_pix", int'(out_pix), hp[2]);
         last_good = hp[2];
      end else begin
         check("R5", "out_valid idle", int'(out_valid), 0);
         check("R9", "out_pix hold", int'(out_pix), last_good);
      end
      hv[2] = hv[1]; hp[2] = hp[1]; ht[2] = ht[1];
      hv[1] = hv[0]; hp[1] = hp[0]; ht[1] = ht[0];
      in_valid = v;
      pix_prev = 8'(a); pix_mid = 8'(n); pix_next = 8'(b); coef_k = 8'(k);
      hv[0] = v;
      hp[0] = model(a, n, b, k);
      ht[0] = tag;
   endtask

   task automatic idle_garbage();
      step(0, int'($urandom_range(255)), int'($urandom_range(255)),
           int'($urandom_range(255)), int'($urandom_range(255)), "R9");
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; in_valid = 1'b0;
      pix_next = '0; pix_mid = '0; pix_prev = '0; coef_k = '0;
      for (int i = 0; i < 3; i++) begin hv[i] = 0; hp[i] = 0; ht[i] = ""; end
      repeat (4) @(negedge clk);
      check("R10", "out_valid after reset", int'(out_valid), 0);
      check("R10", "out_pix after reset", int'(out_pix), 0);
      rst_n = 1'b1;

      // R7: zero coefficient
      for (int i = 0; i < 20; i++)
         step(1, int'($urandom_range(255)), int'($urandom_range(255)),
              int'($urandom_range(255)), 0, "R7");
      // R8: flat column, any coefficient
      for (int i = 0; i < 20; i++) begin
         int p = int'($urandom_range(255));
         step(1, p, p, p, int'($urandom_range(255)), "R8");
      end
      // R4: saturation at both ends, and just inside
      step(1, 0, 255, 0, 255, "R4");
      step(1, 255, 0, 255, 255, "R4");
      step(1, 190, 200, 190, 16, "R4");
      step(1, 0, 255, 0, 16, "R4");
      // R3: rounding around halves in both signs, K = 1/16
      step(1, 96, 100, 97, 1, "R3");
      step(1, 96, 100, 96, 1, "R3");
      step(1, 104, 100, 104, 1, "R3");
      step(1, 105, 100, 104, 1, "R3");
      step(1, 0, 4, 0, 1, "R3");
      // R2: integer and fraction weights
      step(1, 95, 100, 95, 8'h20, "R2");
      step(1, 95, 100, 95, 8'h18, "R2");
      step(1, 95, 100, 95, 8'h08, "R2");
      step(1, 99, 100, 100, 8'hF0, "R2");
      // R9: gaps with garbage on the inputs
      idle_garbage(); idle_garbage(); idle_garbage(); idle_garbage();
      step(1, 10, 60, 20, 8'h30, "R9");
      idle_garbage(); idle_garbage(); idle_garbage(); idle_garbage();
      // R6: coefficient changes on every pixel
      for (int i = 0; i < 16; i++)
         step(1, 80, 120, 90, (i % 2 == 0) ? 8'h00 : 8'h40, "R6");
      // R1 / R5: random traffic with random gaps
      for (int i = 0; i < 3000; i++) begin
         bit v = ($urandom_range(9) < 7);
         step(v, int'($urandom_range(255)), int'($urandom_range(255)),
              int'($urandom_range(255)), int'($urandom_range(255)), "R1");
      end
      for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, "R9");
      finish_run();
   end
endmodule